// File: doc/BRIEF.md
# Audio Codec Register Loader over I2C

After a synchronous reset this block loads a fixed set of ten configuration registers into an audio codec. It is the only master on a two-wire I2C bus. Each register is written in its own bus transaction. A transaction carries the codec's write address byte and then two payload bytes. The payload holds a 7-bit register index followed by a 9-bit register value. The block generates SCL from the system clock and drives SDA open-drain: it can only pull the line low or let it float. The block checks the acknowledge slot after every byte. If the codec does not acknowledge, the block gives up on that transaction and repeats it a bounded number of times.

The only results seen outside the bus are two sticky flags. `done` means the whole table was accepted by the codec. `err` means one register was refused too many times. The block is placed next to the codec pins. Its `sda_oe` output drives a pad that pulls SDA low, and `sda_i` returns the resolved level of the wire.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, SCL is high, SDA is released (`sda_oe` = 0), and `done` and `err` are both low.
- R2: Each transaction has this shape: a START, then byte 0 = 0x34 (device write address), byte 1, byte 2, with every byte sent MSB first and followed by one acknowledge slot, then a STOP. A transaction that is fully acknowledged has 27 clocked bits between START and STOP.
- R3: The registers are sent in index order 0 to 9. Byte 1 is {index[6:0], value[8]} and byte 2 is value[7:0]. The values are: idx0 and idx1 = 0x017, idx2 and idx3 = 0x079, idx4 = 0x014, idx5 = 0x002, idx6 = 0x000, idx7 = 0x001, idx8 = 0x01A, idx9 = 0x001.
- R4: In every acknowledge slot the master releases SDA for the whole SCL-high phase. SDA is only ever pulled low and is never driven high.
- R5: SDA changes only while SCL is low. The only exceptions are a falling edge with the bus idle (START) and a rising edge right after a complete acknowledge slot (STOP). SDA never changes on the same clock edge as SCL.
- R6: If an acknowledge slot reads high, that transaction ends with a STOP immediately after the slot, and no further byte of it is sent.
- R7: A transaction that is not acknowledged is repeated for the same register index, up to 3 repeats (4 attempts in total). An acknowledged attempt moves on to the next index.
- R8: After the 4th unacknowledged attempt on a register, `err` rises and stays high until reset, `done` stays low, and the bus stays idle (SCL high, SDA released) with no further START.
- R9: `done` rises only after index 9 has been acknowledged and its STOP has been sent. It then stays high until reset, with the bus idle.
- R10: Each SCL high phase of a data bit lasts 2·Q system clocks, where Q = CLK_HZ / (4·SCL_HZ). With the default 50 MHz and 20 kHz this gives Q = 625.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_o | output | 1 | I2C clock line level driven by the master |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_i | input | 1 | Resolved SDA wire level |
| done | output | 1 | Sticky: whole table accepted |
| err | output | 1 | Sticky: one register refused on all attempts |

## Verification
Errors inside the block show up at the pins quickly. A wrong bit pointer or a wrong shift register shows as a wrong byte at the STOP that ends that same transaction. An off-by-one in the retry counter shows as one transaction too many or too few on the bus. It can also show as `err` rising at the wrong attempt, or `done` rising while the codec still refused a register. A bench-side slave that decodes the wire and keeps its own model of index and retry count therefore finds a wrong register within one transaction. It compares the sticky flags against that model on every clock, so a flag raised too early is caught in the cycle it appears.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

    localparam int CFG_COUNT = 10;
    localparam int IDX_W     = 7;
    localparam int VAL_W     = 9;
    localparam int SEL_W     = 4;
    localparam int FRAME_W   = 8 + IDX_W + VAL_W;
    localparam logic [7:0] CODEC_WR_ADDR = 8'h34;

    typedef logic [VAL_W-1:0] cfg_val_t;
    typedef logic [SEL_W-1:0] cfg_sel_t;

    typedef struct packed {
        logic [7:0]       dev;
        logic [IDX_W-1:0] idx;
        cfg_val_t         val;
    } cfg_frame_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_START,
        BUS_BITS,
        BUS_STOP
    } bus_state_t;

    typedef enum logic [1:0] {
        SQ_ISSUE,
        SQ_WAIT,
        SQ_DONE,
        SQ_FAIL
    } seq_state_t;

    // Register contents, in the order they are written.
    function automatic cfg_val_t cfg_value(input cfg_sel_t n);
        cfg_val_t v;
        unique case (n)
            4'd0, 4'd1: v = 9'h017;
            4'd2, 4'd3: v = 9'h079;
            4'd4:       v = 9'h014;
            4'd5:       v = 9'h002;
            4'd6:       v = 9'h000;
            4'd7:       v = 9'h001;
            4'd8:       v = 9'h01A;
            4'd9:       v = 9'h001;
            default:    v = 9'h000;
        endcase
        return v;
    endfunction

    function automatic cfg_frame_t cfg_pack(input cfg_sel_t n);
        cfg_frame_t f;
        f.dev = CODEC_WR_ADDR;
        f.idx = {{(IDX_W-SEL_W){1'b0}}, n};
        f.val = cfg_value(n);
        return f;
    endfunction

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
    parameter int DIV = 625
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
    import codec_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  cfg_frame_t frame_in,
    input  logic       sda_in,
    output logic       scl_o,
    output logic       sda_low_o,
    output logic       fin_o,
    output logic       nack_o
);
    bus_state_t         st;
    logic [1:0]         q;
    logic [FRAME_W-1:0] sr;
    logic [1:0]         byte_n;
    logic [3:0]         pos;
    logic               scl_q, low_q, nack_q, fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= BUS_IDLE;
            q      <= 2'd0;
            sr     <= '0;
            byte_n <= 2'd0;
            pos    <= 4'd0;
            scl_q  <= 1'b1;
            low_q  <= 1'b0;
            nack_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            unique case (st)
                BUS_IDLE: begin
                    if (go) begin
                        st     <= BUS_START;
                        q      <= 2'd0;
                        sr     <= frame_in;
                        byte_n <= 2'd0;
                        pos    <= 4'd0;
                        nack_q <= 1'b0;
                    end
                end
                BUS_START: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        unique case (q)
                            2'd0: begin scl_q <= 1'b1; low_q <= 1'b0; end
                            2'd1: low_q <= 1'b1;
                            2'd2: scl_q <= 1'b0;
                            default: st <= BUS_BITS;
                        endcase
                    end
                end
                BUS_BITS: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        unique case (q)
                            2'd0: begin
                                scl_q <= 1'b0;
                                low_q <= (pos == 4'd8) ? 1'b0 : ~sr[FRAME_W-1];
                            end
                            2'd1: scl_q <= 1'b1;
                            2'd2: begin
                                if (pos == 4'd8 && sda_in) nack_q <= 1'b1;
                            end
                            default: begin
                                scl_q <= 1'b0;
                                if (pos == 4'd8) begin
                                    pos <= 4'd0;
                                    if (nack_q || byte_n == 2'd2) st <= BUS_STOP;
                                    else                         byte_n <= byte_n + 2'd1;
                                end else begin
                                    pos <= pos + 4'd1;
                                    sr  <= {sr[FRAME_W-2:0], 1'b0};
                                end
                            end
                        endcase
                    end
                end
                BUS_STOP: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        unique case (q)
                            2'd0: low_q <= 1'b1;
                            2'd1: scl_q <= 1'b1;
                            2'd2: low_q <= 1'b0;
                            default: begin
                                st    <= BUS_IDLE;
                                fin_q <= 1'b1;
                            end
                        endcase
                    end
                end
                default: st <= BUS_IDLE;
            endcase
        end
    end

    assign scl_o     = scl_q;
    assign sda_low_o = low_q;
    assign fin_o     = fin_q;
    assign nack_o    = nack_q;
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import codec_cfg_pkg::*;
#(
    parameter int MAX_RETRY = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fin,
    input  logic       nack,
    output logic       go,
    output cfg_frame_t frame_out,
    output logic       done,
    output logic       err
);
    localparam int TW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [TW-1:0] TRY_LIM  = TW'(MAX_RETRY);
    localparam cfg_sel_t      LAST_SEL = SEL_W'(CFG_COUNT - 1);

    seq_state_t     st;
    cfg_sel_t       sel;
    logic [TW-1:0]  tries;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_ISSUE;
            sel   <= '0;
            tries <= '0;
        end else begin
            unique case (st)
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (fin) begin
                        if (nack) begin
                            if (tries == TRY_LIM) st <= SQ_FAIL;
                            else begin
                                tries <= tries + 1'b1;
                                st    <= SQ_ISSUE;
                            end
                        end else if (sel == LAST_SEL) begin
                            st <= SQ_DONE;
                        end else begin
                            sel   <= sel + 1'b1;
                            tries <= '0;
                            st    <= SQ_ISSUE;
                        end
                    end
                end
                SQ_DONE: st <= SQ_DONE;
                default: st <= SQ_FAIL;
            endcase
        end
    end

    assign go        = (st == SQ_ISSUE);
    assign frame_out = cfg_pack(sel);
    assign done      = (st == SQ_DONE);
    assign err       = (st == SQ_FAIL);
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
    import codec_cfg_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SCL_HZ    = 20_000,
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst,
    output logic scl_o,
    output logic sda_oe,
    input  logic sda_i,
    output logic done,
    output logic err
);
    localparam int QRAW    = CLK_HZ / (4 * SCL_HZ);
    localparam int QUARTER = (QRAW < 1) ? 1 : QRAW;

    logic       tick, go, fin, nack;
    cfg_frame_t frame;

    cfg_tick_gen #(.DIV(QUARTER)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cfg_seq_ctrl #(.MAX_RETRY(MAX_RETRY)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fin       (fin),
        .nack      (nack),
        .go        (go),
        .frame_out (frame),
        .done      (done),
        .err       (err)
    );

    i2c_wr_engine i_eng (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .go        (go),
        .frame_in  (frame),
        .sda_in    (sda_i),
        .scl_o     (scl_o),
        .sda_low_o (sda_oe),
        .fin_o     (fin),
        .nack_o    (nack)
    );
endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk (
    input logic clk,
    input logic rst,
    input logic scl_o,
    input logic sda_oe,
    input logic done,
    input logic err
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (scl_o && !sda_oe && !done && !err));

    assert_no_sda_edge_on_scl_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_o) |-> $stable(sda_oe));

    assert_no_sda_edge_on_scl_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_o) |-> $stable(sda_oe));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl_o && !sda_oe && !err));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && !done));

    assert_idle_after_err_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (scl_o && !sda_oe));

    assert_scl_high_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_o) |=> scl_o);
endmodule

bind codec_cfg_seq codec_cfg_seq_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_o  (scl_o),
    .sda_oe (sda_oe),
    .done   (done),
    .err    (err)
);

// File: tb/test_codec_cfg_seq.sv
`timescale 1ns/1ps
module test_codec_cfg_seq;
    localparam int TB_CLK_HZ = 200;
    localparam int TB_SCL_HZ = 10;
    localparam int Q         = TB_CLK_HZ / (4 * TB_SCL_HZ);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl, sda_oe, sda_i, done, err;
    logic slave_pull = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    // slave NACK plan: attempts in [nk_lo, nk_hi] refuse byte nk_byte
    int nk_lo = -1, nk_hi = -1, nk_byte = 0;

    // monitor / reference model state
    int   in_frame, bitcnt, nacked, nack_at, hi_cnt, attempt;
    int   m_reg, m_tries, m_done, m_err;
    logic p_scl, p_sda;
    logic [7:0] cur;
    logic [7:0] got [3];

    always #2.5 clk = ~clk;

    assign sda_i = !(sda_oe || slave_pull);

    codec_cfg_seq #(.CLK_HZ(TB_CLK_HZ), .SCL_HZ(TB_SCL_HZ), .MAX_RETRY(3)) i_codec_cfg_seq (
        .clk    (clk),
        .rst    (rst),
        .scl_o  (scl),
        .sda_oe (sda_oe),
        .sda_i  (sda_i),
        .done   (done),
        .err    (err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_val(input int r);
        case (r)
            0, 1: return 'h017;
            2, 3: return 'h079;
            4:    return 'h014;
            5:    return 'h002;
            6:    return 'h000;
            7:    return 'h001;
            8:    return 'h01A;
            default: return 'h001;
        endcase
    endfunction

    function automatic int ref_byte(input int r, input int b);
        int v;
        v = ref_val(r);
        if (b == 0) return 'h34;
        if (b == 1) return ((r & 'h7f) << 1) | ((v >> 8) & 1);
        return v & 'hff;
    endfunction

    function automatic bit slave_refuses(input int b);
        return (attempt >= nk_lo) && (attempt <= nk_hi) && (b == nk_byte);
    endfunction

    // bus decoder, behavioural slave and reference model
    always @(negedge clk) begin
        logic sda_now;
        sda_now = !(sda_oe || slave_pull);
        if (rst) begin
            in_frame = 0; bitcnt = 0; nacked = 0; nack_at = 0; hi_cnt = 0;
            attempt = 0; m_reg = 0; m_tries = 0; m_done = 0; m_err = 0;
            slave_pull = 1'b0; p_scl = 1'b1; p_sda = 1'b1; cur = 8'h00;
        end else begin
            chk(!(done && !m_done), "R9 done vs model", int'(done), m_done);
            chk(!(err && !m_err), "R8 err vs model", int'(err), m_err);
            if (p_scl && scl) begin
                hi_cnt++;
                if (p_sda && !sda_now) begin
                    chk(in_frame == 0, "R5 START inside frame", in_frame, 0);
                    in_frame = 1; bitcnt = 0; nacked = 0;
                end else if (!p_sda && sda_now) begin
                    int nbits;
                    nbits = bitcnt - 1;
                    chk(in_frame == 1 && (nbits % 9) == 0, "R5 STOP position", nbits, 9 * (nbits / 9));
                    chk(m_done == 0 && m_err == 0, "R8 no frame after end", m_done + m_err, 0);
                    for (int b = 0; b < nbits / 9; b++)
                        chk(int'(got[b]) == ref_byte(m_reg, b),
                            (b == 0) ? "R2 address byte" : "R3 register byte",
                            int'(got[b]), ref_byte(m_reg, b));
                    if (nacked) chk(nbits == 9 * (nack_at + 1), "R6 stop after NACK", nbits, 9 * (nack_at + 1));
                    else        chk(nbits == 27, "R2 frame length", nbits, 27);
                    if (nacked) begin
                        m_tries++;
                        if (m_tries > 3) m_err = 1;
                    end else begin
                        m_reg++; m_tries = 0;
                        if (m_reg == 10) m_done = 1;
                    end
                    attempt++;
                    in_frame = 0;
                end
            end else if (!p_scl && scl) begin
                hi_cnt = 1;
                if (in_frame) begin
                    if ((bitcnt % 9) < 8) cur = {cur[6:0], sda_now};
                    else begin
                        got[bitcnt / 9] = cur;
                        chk(!sda_oe, "R4 master releases ack slot", int'(sda_oe), 0);
                        if (sda_now && !nacked) begin nacked = 1; nack_at = bitcnt / 9; end
                    end
                    bitcnt++;
                end
            end else if (p_scl && !scl) begin
                if (in_frame && bitcnt == 1) chk(hi_cnt == 2 * Q, "R10 SCL high width", hi_cnt, 2 * Q);
                if (in_frame && (bitcnt % 9) == 8 && bitcnt < 27) slave_pull = !slave_refuses(bitcnt / 9);
                else slave_pull = 1'b0;
            end
            p_scl = scl;
            p_sda = !(sda_oe || slave_pull);
        end
    end

    task automatic apply_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(scl && !sda_oe && !done && !err, "R1 reset state",
            {28'd0, scl, sda_oe, done, err}, 8);
        rst = 1'b0;
        @(negedge clk);
        chk(scl && !sda_oe && !done && !err, "R1 first cycle after reset",
            {28'd0, scl, sda_oe, done, err}, 8);
    endtask

    task automatic wait_end(input int lim);
        for (int i = 0; i < lim && !(done || err); i++) @(negedge clk);
    endtask

    initial begin
        #(150_000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // all registers acknowledged
        nk_lo = -1; nk_hi = -1;
        apply_reset();
        wait_end(20_000);
        chk(done == 1'b1 && err == 1'b0, "R9 done after full table", int'(done), 1);
        chk(attempt == 10, "R3 ten transactions in order", attempt, 10);
        repeat (400) @(negedge clk);
        chk(done && scl && !sda_oe, "R9 done sticky, bus idle", int'(done && scl && !sda_oe), 1);
        chk(attempt == 10, "R9 no bus activity after done", attempt, 10);

        // address refused twice on index 3, then accepted
        nk_lo = 3; nk_hi = 4; nk_byte = 0;
        apply_reset();
        wait_end(20_000);
        chk(done == 1'b1 && err == 1'b0, "R7 recovery after retries", int'(done), 1);
        chk(attempt == 12, "R7 attempt count with two retries", attempt, 12);

        // second payload byte of index 5 always refused
        nk_lo = 5; nk_hi = 1000; nk_byte = 2;
        apply_reset();
        wait_end(20_000);
        chk(err == 1'b1 && done == 1'b0, "R8 error after four refusals", int'(err), 1);
        chk(attempt == 9, "R7 four attempts on index 5", attempt, 9);
        repeat (3000) @(negedge clk);
        chk(attempt == 9, "R8 no START after error", attempt, 9);
        chk(err && !done && scl && !sda_oe, "R8 err sticky, bus idle",
            int'(err && !done && scl && !sda_oe), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule